// File: doc/BRIEF.md
# Buffered down-counting PWM timer

This block is a single PWM timer channel. Software stages a period value and a threshold value in buffer registers. Neither value affects the running channel until a manual-load strobe copies both into the working registers, or until an automatic reload at the end of a period does so. The working counter steps down by one on each timer tick. Once the threshold is met after a step, the output pin leaves its idle level. When the counter has run out, the block pulses an interrupt, returns the pin to its idle level and, in repeat mode, starts the next period from the buffers.

Ticks come from an 8-bit prescaler followed by a power-of-two divider picked by a 4-bit code. Software therefore trades period resolution against range without changing the counter width. A polarity bit flips the pin, and a run bit freezes or releases the channel.

Top module: `pwm_timer_chan`

## Requirements
- R1: Let N be the working period value and T the tick interval in clocks. In repeat mode, consecutive interrupt pulses are exactly (N+1)*T clock cycles apart: N down-steps from N to 0, then one expiry tick.
- R2: Writes to the period buffer (wr_sel 0) or the threshold buffer (wr_sel 1) do not change the running period. The new values take effect only through a manual load or at the next expiry reload.
- R3: With threshold C below N and polarity 0, pwm_out is 1 for (N-C)*T cycles after each reload. It is 0 for the remaining (C+1)*T cycles of the period.
- R4: A threshold equal to or above the loaded period value never produces a match after a down-step, so pwm_out stays at its idle level for the whole period.
- R5: With repeat mode set (control bit 3), expiry reloads both buffers and counting continues without software action.
- R6: Polarity bit (control bit 2) set to 1 inverts pwm_out, so the idle level becomes 0.
- R7: Counting and interrupts happen only while the run bit (control bit 0) is 1. Clearing it freezes the counter and the pin.
- R8: The tick interval is T = (P+1)*D clocks. P is the 8-bit prescale value in wr_data[7:0] of a wr_sel 3 write. D is set by the code in wr_data[11:8]: 0→1, 1→2, 2→4, 3→8, 4→16.
- R9: Divider codes 5 to 15 select a divide of 16.
- R10: With repeat mode clear, the channel stops at zero after one expiry. It raises no further interrupt and holds pwm_out at its idle level until the next manual load.
- R11: Every expiry raises irq for exactly one clock cycle, in the cycle after the expiry tick.
- R12: After reset, pwm_out is 1 and irq is 0, and all registers are zero. The channel is parked, so setting only the run bit produces no interrupt until a manual load (control bit 1) has been issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 period buffer, 1 threshold buffer, 2 control nibble, 3 clock setup |
| wr_data | input | CNT_W | Write data; control bits are [0] run, [1] manual load, [2] polarity, [3] repeat |
| pwm_out | output | 1 | PWM pin |
| irq | output | 1 | One-cycle expiry pulse |

## Verification
The assertions assume that the clock setup register is changed only while the run bit is clear. A prescale value lowered mid-count would otherwise leave the prescaler beyond its limit. They also assume that the manual-load bit is never held together with the run bit during a reconfiguration. The stimulus follows both rules: before any new setting, it stops the channel with a control write of zero, then writes the clock setup and both buffers, pulses the manual load, and only then sets the run bit on its own. Every period used is nonzero, so interrupt pulses never merge into a level.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int CNT_W_DEF   = 16;
    localparam int PRE_W_DEF   = 8;
    localparam int DIV_W_DEF   = 4;
    localparam int DIV_LOG_MAX = 4;

    // control nibble, bit 0 is run
    typedef struct packed {
        logic repeat_en;
        logic polarity;
        logic man_load;
        logic run;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_THRESH = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_CLOCK  = 2'd3
    } reg_sel_e;

    // low-bit mask for the divider counter: code k gives 2**k - 1, codes above the max saturate
    function automatic logic [DIV_LOG_MAX-1:0] div_mask(input logic [DIV_W_DEF-1:0] code);
        int shift;
        logic [DIV_LOG_MAX-1:0] m;
        shift = (int'(code) > DIV_LOG_MAX) ? DIV_LOG_MAX : int'(code);
        for (int i = 0; i < DIV_LOG_MAX; i++) begin
            m[i] = (i < shift);
        end
        return m;
    endfunction

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen
    import pwm_timer_pkg::*;
#(
    parameter int PRE_W = PRE_W_DEF,
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PRE_W-1:0] prescale,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);

    logic [PRE_W-1:0]       pre_cnt;
    logic [DIV_LOG_MAX-1:0] div_cnt;
    logic [DIV_LOG_MAX-1:0] mask;
    logic                   pre_hit;

    assign pre_hit = (pre_cnt == prescale);
    assign mask    = div_mask(DIV_W_DEF'(div_code));
    assign tick    = run && pre_hit && ((div_cnt & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (pre_hit) begin
            pre_cnt <= '0;
            div_cnt <= div_cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // prescaler never runs past its limit while the channel is live
    assert_pre_in_range_R8: assert property (@(posedge clk) disable iff (rst)
        run |-> (pre_cnt <= prescale));

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic             man_load,
    input  logic             repeat_en,
    input  logic [CNT_W-1:0] period_buf,
    input  logic [CNT_W-1:0] thresh_buf,
    output logic             matched,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             parked_q;
    logic             phase_q;
    logic             expire_q;
    logic             step;
    logic             at_zero;

    assign cnt_dec = cnt_q - 1'b1;
    assign at_zero = (cnt_q == '0);
    assign step    = tick && run && !man_load && !parked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            thr_q    <= '0;
            parked_q <= 1'b1;
            phase_q  <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (man_load) begin
                cnt_q    <= period_buf;
                thr_q    <= thresh_buf;
                phase_q  <= 1'b0;
                parked_q <= 1'b0;
            end else if (step) begin
                if (at_zero) begin
                    expire_q <= 1'b1;
                    phase_q  <= 1'b0;
                    if (repeat_en) begin
                        cnt_q <= period_buf;
                        thr_q <= thresh_buf;
                    end else begin
                        parked_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_dec;
                    if (cnt_dec == thr_q) begin
                        phase_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign matched = phase_q;
    assign expire  = expire_q;

    assert_count_down_R1: assert property (@(posedge clk) disable iff (rst)
        (step && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_buffers_isolated_R2: assert property (@(posedge clk) disable iff (rst)
        (!man_load && !(step && at_zero && repeat_en)) |=> $stable(thr_q));

    assert_match_after_step_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_q) |-> ((cnt_q == thr_q) && $past(step)));

    assert_frozen_when_stopped_R7: assert property (@(posedge clk) disable iff (rst)
        (!run && !man_load) |=> $stable(cnt_q));

    assert_parked_idle_R10: assert property (@(posedge clk) disable iff (rst)
        parked_q |-> (!phase_q && at_zero));

    assert_expire_follows_tick_R11: assert property (@(posedge clk) disable iff (rst)
        expire_q |-> $past(step));

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF,
    parameter int PRE_W = PRE_W_DEF,
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             pwm_out,
    output logic             irq
);

    localparam int CLK_HI = PRE_W + DIV_W - 1;

    logic [CNT_W-1:0] period_buf;
    logic [CNT_W-1:0] thresh_buf;
    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] prescale_q;
    logic [DIV_W-1:0] div_code_q;
    logic             tick;
    logic             matched;
    logic             expire;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_buf <= '0;
            thresh_buf <= '0;
            ctrl_q     <= '0;
            prescale_q <= '0;
            div_code_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_PERIOD: period_buf <= wr_data;
                SEL_THRESH: thresh_buf <= wr_data;
                SEL_CTRL:   ctrl_q     <= ctrl_t'(wr_data[3:0]);
                SEL_CLOCK: begin
                    prescale_q <= wr_data[PRE_W-1:0];
                    div_code_q <= wr_data[CLK_HI:PRE_W];
                end
                default: ;
            endcase
        end
    end

    pwm_tick_gen #(
        .PRE_W (PRE_W),
        .DIV_W (DIV_W)
    ) tick_i (
        .clk      (clk),
        .rst      (rst),
        .run      (ctrl_q.run),
        .prescale (prescale_q),
        .div_code (div_code_q),
        .tick     (tick)
    );

    pwm_count_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .run        (ctrl_q.run),
        .man_load   (ctrl_q.man_load),
        .repeat_en  (ctrl_q.repeat_en),
        .period_buf (period_buf),
        .thresh_buf (thresh_buf),
        .matched    (matched),
        .expire     (expire)
    );

    // idle level is 1 before the match, flipped by polarity
    assign pwm_out = ~(matched ^ ctrl_q.polarity);
    assign irq     = expire;

    assert_irq_single_R11: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

endmodule

// File: tb/pwm_timer_chan_tb_top.sv
`timescale 1ns/1ps
module pwm_timer_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwm_timer_chan dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .pwm_out(pwm_out), .irq(irq)
    );

    // N, C, P, divider code, polarity
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{9, 4, 0, 0, 0},
        '{7, 2, 2, 1, 0},
        '{5, 1, 1, 2, 1},
        '{3, 0, 0, 3, 0},
        '{4, 3, 0, 4, 0},
        '{4, 2, 0, 9, 0},
        '{6, 6, 0, 0, 0},
        '{6, 10, 0, 0, 0}
    };

    function automatic int divisor(int code);
        return (code > 4) ? 16 : (1 << code);
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // ctrl nibble: {repeat, polarity, manual load, run}
    task automatic setup(int n, int c, int p, int code, int inv, int rep);
        wr(2, 0);
        wr(3, (code << 8) | p);
        wr(0, n);
        wr(1, c);
        wr(2, (rep << 3) | (inv << 2) | 2);
        wr(2, (rep << 3) | (inv << 2) | 1);
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1; break; end
        end
    endtask

    task automatic measure(int lvl, output int per, output int hi);
        per = 0; hi = 0;
        do begin
            if (pwm_out == lvl[0]) hi++;
            per++;
            @(negedge clk);
        end while (!irq && per < 4000);
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL R1 watchdog act=hung exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        bit ok;
        int per, hi, cnt, chg;
        logic last;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R12 pwm_out after reset", int'(pwm_out), 1);
        check("R12 irq after reset", int'(irq), 0);

        // run without a manual load: parked
        wr(2, 9);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (irq) cnt++; end
        check("R12 no irq before first load", cnt, 0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            int n, c, p, code, inv, t, eper, ehi, lvl;
            string tg;
            n = VEC[v][0]; c = VEC[v][1]; p = VEC[v][2]; code = VEC[v][3]; inv = VEC[v][4];
            t = (p + 1) * divisor(code);
            eper = (n + 1) * t;
            ehi = (c < n) ? (n - c) * t : eper;
            lvl = inv ? 0 : 1;
            tg = inv ? "R6" : (c >= n) ? "R4" : (code > 4) ? "R9" : "R3";
            setup(n, c, p, code, inv, 1);
            wait_irq(ok);
            check("R5 first expiry seen", int'(ok), 1);
            measure(lvl, per, hi);
            check((code > 4) ? "R9 period" : "R1/R8 period", per, eper);
            check({tg, " idle-level time"}, hi, ehi);
        end

        // irq width
        setup(9, 4, 0, 0, 0, 1);
        wait_irq(ok);
        @(negedge clk);
        check("R11 irq low after one cycle", int'(irq), 0);

        // buffer write mid-period
        wait_irq(ok);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 16'd19;
        per = 0;
        do begin
            per++;
            @(negedge clk);
            wr_en = 1'b0;
        end while (!irq && per < 4000);
        check("R2 running period unchanged by buffer write", per, 10);
        measure(1, per, hi);
        check("R5 reload picks new period", per, 20);
        check("R3 new idle-level time", hi, 15);

        // stop by clearing run
        setup(9, 4, 0, 0, 0, 1);
        wait_irq(ok);
        repeat (3) @(negedge clk);
        wr(2, 8);
        cnt = 0; chg = 0; last = pwm_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq) cnt++;
            if (pwm_out != last) chg++;
        end
        check("R7 no irq while stopped", cnt, 0);
        check("R7 pin frozen while stopped", chg, 0);
        wr(2, 9);
        wait_irq(ok);
        check("R7 resumes after run set", int'(ok), 1);

        // one-shot
        setup(5, 2, 0, 0, 0, 0);
        wait_irq(ok);
        check("R10 single expiry", int'(ok), 1);
        cnt = 0; chg = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq) cnt++;
            if (pwm_out != 1'b1) chg++;
        end
        check("R10 no further irq", cnt, 0);
        check("R10 pin held idle", chg, 0);

        finished = 1;
        summary();
        $finish;
    end

endmodule